// File: doc/BRIEF.md
# Nine-bit multiprocessor UART port

This block is a full-duplex serial port with an eight-bit control register. It sends and receives frames of one low start bit, eight data bits least significant first, an optional ninth bit, and one high stop bit. The line rests high between frames. One control bit selects the frame length. In nine-bit framing the extra bit can mark a frame as an address, so that several receivers on a shared line can ignore data meant for other nodes.

The block does not generate its own bit rate. A one-cycle `baud_tick` pulse arrives sixteen times per bit period. The transmitter holds each bit for sixteen ticks. The receiver confirms the start bit at its midpoint and then samples every later bit at mid-bit. Two sticky flags report activity: a transmit-done flag and a receive-done flag. Only software can clear them, by writing the control register. While either flag is set and `irq_en` is high, they raise a registered interrupt request.

One control bit is a qualifier whose role depends on the framing. In eight-bit framing it rejects frames whose stop bit reads low. In nine-bit framing it rejects frames whose ninth bit is low. A rejected frame leaves the receive data and the captured-bit field untouched.

Top module: `mpu_uart`

## Requirements
- R1: After reset the control register reads 0x40, `txd` is 1, `irq` is 0 and `rx_data` is 0.
- R2: Control layout, MSB first: bit 7 framing (0 = eight data bits, 1 = nine), bit 6 constant 1, bit 5 qualifier, bit 4 receive enable, bit 3 transmitted ninth bit, bit 2 captured bit, bit 1 transmit-done flag, bit 0 receive-done flag. Bit 6 always reads 1 and bit 2 is never changed by a write, so writing 0xFF reads back 0xFB.
- R3: An accepted `tx_we` sends 0, then `tx_data` LSB first, then control bit 3 (nine-bit framing only), then 1, with each bit lasting 16 ticks. The line stays at 1 when idle.
- R4: The transmit-done flag rises at the start of the stop bit. In eight-bit framing this is after the eighth data bit. In nine-bit framing it is after the ninth bit.
- R5: With receive enable set and the qualifier clear, a received frame loads `rx_data`, sets the receive-done flag, and loads bit 2 with the ninth bit (nine-bit framing) or the stop bit (eight-bit framing).
- R6: With receive enable clear, incoming frames leave `rx_data` and the receive-done flag unchanged.
- R7: In eight-bit framing with the qualifier set, a frame whose stop bit is 0 is rejected and one whose stop bit is 1 is accepted.
- R8: In nine-bit framing with the qualifier set, a frame whose ninth bit is 0 is rejected and one whose ninth bit is 1 is accepted.
- R9: A rejected frame keeps the previous `rx_data` and bit 2.
- R10: A low pulse on `rxd` that has ended by the start-bit midpoint produces no frame.
- R11: Hardware only ever sets the two flags. A control write of 0 clears them. When a hardware set and a clearing write fall in the same cycle, the flag ends up set.
- R12: `irq` equals `irq_en` AND (transmit-done OR receive-done), delayed by one clock.
- R13: A `tx_we` while a frame is being sent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Pulse at 16 times the bit rate |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value |
| ctl_rdata | output | 8 | Control register contents |
| tx_we | input | 1 | Start sending `tx_data` |
| tx_data | input | DW | Byte to send |
| rx_data | output | DW | Last accepted received byte |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Registered interrupt request |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The case that needs care is when the receiver sets the receive-done flag at the stop-bit sample in the same clock edge as a software write that clears the flag. The bench sends the same frame about two dozen times. Each time it moves the clearing write one cycle later, so the sweep passes across the sample point. The bench notes whether the flag was already visible just before its write. The flag must read 0 afterwards exactly when it was visible before the write, and 1 otherwise. The sweep must also produce both outcomes at least once.

// File: rtl/mpu_pkg.sv
`timescale 1ns/1ps
package mpu_pkg;
  typedef enum logic {FRAME_8 = 1'b0, FRAME_9 = 1'b1} frame_mode_e;

  typedef struct packed {
    frame_mode_e mode;
    logic        mce;
    logic        ren;
    logic        tb8;
  } uart_cfg_t;

  // control register bit positions
  localparam int CTL_MODE = 7;
  localparam int CTL_ONE  = 6;
  localparam int CTL_MCE  = 5;
  localparam int CTL_REN  = 4;
  localparam int CTL_TB8  = 3;
  localparam int CTL_RB8  = 2;
  localparam int CTL_TI   = 1;
  localparam int CTL_RI   = 0;
endpackage

// File: rtl/mpu_tx.sv
`timescale 1ns/1ps
module mpu_tx
  import mpu_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  frame_mode_e   mode,
  input  logic          tb8,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW + 3);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW:0]   sh;
  logic          nine;
  logic [IW-1:0] stop_idx;

  // bit index: 0 start, 1..DW data, DW+1 ninth (if present), then stop
  assign stop_idx = nine ? IW'(DW + 2) : IW'(DW + 1);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      nine <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        busy <= 1'b1;
        txd  <= 1'b0;
        cnt  <= '0;
        idx  <= '0;
        sh   <= {tb8, data};
        nine <= (mode == FRAME_9);
      end
    end else if (tick) begin
      if (cnt != CNT_LAST) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (idx == stop_idx) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
          if (idx + 1'b1 == stop_idx) begin
            txd  <= 1'b1;
            done <= 1'b1;
          end else begin
            txd <= sh[0];
            sh  <= sh >> 1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mpu_rx.sv
`timescale 1ns/1ps
module mpu_rx
  import mpu_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          ren,
  input  frame_mode_e   mode,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ninth,
  output logic          stop
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW + 2);
  localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  rx_state_e     state;
  logic [1:0]    sync;
  logic          line_q;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW:0]   sh;
  logic          nine;
  logic [IW-1:0] n_pay;

  assign n_pay = nine ? IW'(DW + 1) : IW'(DW);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      sync   <= '1;
      line_q <= 1'b1;
      state  <= RX_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      nine   <= 1'b0;
      data   <= '0;
      ninth  <= 1'b0;
      stop   <= 1'b1;
    end else begin
      sync   <= {sync[0], rxd};
      line_q <= sync[1];
      if (!ren) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: begin
            if (line_q && !sync[1]) begin
              state <= RX_START;
              cnt   <= '0;
              nine  <= (mode == FRAME_9);
            end
          end
          RX_START: begin
            if (tick) begin
              if (cnt == CNT_HALF) begin
                cnt   <= '0;
                idx   <= '0;
                state <= sync[1] ? RX_IDLE : RX_BITS;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          RX_BITS: begin
            if (tick) begin
              if (cnt == CNT_LAST) begin
                cnt <= '0;
                if (idx == n_pay) begin
                  state <= RX_IDLE;
                  done  <= 1'b1;
                  stop  <= sync[1];
                  data  <= nine ? sh[DW-1:0] : sh[DW:1];
                  ninth <= sh[DW];
                end else begin
                  sh  <= {sync[1], sh[DW:1]};
                  idx <= idx + 1'b1;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpu_ctl.sv
`timescale 1ns/1ps
module mpu_ctl
  import mpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [7:0]    wdata,
  input  logic          irq_en,
  input  logic          tx_done,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_word,
  input  logic          rx_ninth,
  input  logic          rx_stop,
  output uart_cfg_t     cfg,
  output logic [7:0]    rdata,
  output logic [DW-1:0] rx_rdata,
  output logic          irq
);
  logic ti, ri, rb8;
  logic rx_bit9, rx_ok;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[CTL_ONE], wdata[CTL_RB8]};
  // the qualified bit is the ninth bit or the stop bit depending on framing
  assign rx_bit9 = (cfg.mode == FRAME_9) ? rx_ninth : rx_stop;
  assign rx_ok   = rx_done && !(cfg.mce && !rx_bit9);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      ti       <= 1'b0;
      ri       <= 1'b0;
      rb8      <= 1'b0;
      rx_rdata <= '0;
      irq      <= 1'b0;
    end else begin
      if (we) begin
        cfg <= '{mode: frame_mode_e'(wdata[CTL_MODE]), mce: wdata[CTL_MCE],
                 ren: wdata[CTL_REN], tb8: wdata[CTL_TB8]};
      end
      ti <= tx_done | (we ? wdata[CTL_TI] : ti);
      ri <= rx_ok   | (we ? wdata[CTL_RI] : ri);
      if (rx_ok) begin
        rx_rdata <= rx_word;
        rb8      <= rx_bit9;
      end
      irq <= irq_en && (ti || ri);
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[CTL_MODE] = cfg.mode;
    rdata[CTL_ONE]  = 1'b1;
    rdata[CTL_MCE]  = cfg.mce;
    rdata[CTL_REN]  = cfg.ren;
    rdata[CTL_TB8]  = cfg.tb8;
    rdata[CTL_RB8]  = rb8;
    rdata[CTL_TI]   = ti;
    rdata[CTL_RI]   = ri;
  end
endmodule

// File: rtl/mpu_uart.sv
`timescale 1ns/1ps
module mpu_uart
  import mpu_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          tx_we,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] rx_data,
  input  logic          irq_en,
  output logic          irq,
  output logic          txd,
  input  logic          rxd
);
  uart_cfg_t     cfg;
  logic          tx_busy, tx_done;
  logic          rx_done, rx_ninth, rx_stop;
  logic [DW-1:0] rx_word;

  mpu_tx #(.OVS(OVS), .DW(DW)) tx_i (
    .clk  (clk),
    .rst  (rst),
    .tick (baud_tick),
    .load (tx_we && !tx_busy),
    .data (tx_data),
    .mode (cfg.mode),
    .tb8  (cfg.tb8),
    .txd  (txd),
    .busy (tx_busy),
    .done (tx_done)
  );

  mpu_rx #(.OVS(OVS), .DW(DW)) rx_i (
    .clk   (clk),
    .rst   (rst),
    .tick  (baud_tick),
    .rxd   (rxd),
    .ren   (cfg.ren),
    .mode  (cfg.mode),
    .done  (rx_done),
    .data  (rx_word),
    .ninth (rx_ninth),
    .stop  (rx_stop)
  );

  mpu_ctl #(.DW(DW)) ctl_i (
    .clk      (clk),
    .rst      (rst),
    .we       (ctl_we),
    .wdata    (ctl_wdata),
    .irq_en   (irq_en),
    .tx_done  (tx_done),
    .rx_done  (rx_done),
    .rx_word  (rx_word),
    .rx_ninth (rx_ninth),
    .rx_stop  (rx_stop),
    .cfg      (cfg),
    .rdata    (ctl_rdata),
    .rx_rdata (rx_data),
    .irq      (irq)
  );
endmodule

// File: rtl/mpu_uart_chk.sv
`timescale 1ns/1ps
module mpu_uart_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_we,
  input logic [7:0] ctl_rdata,
  input logic       irq_en,
  input logic       irq,
  input logic       txd,
  input logic       tx_busy,
  input logic       rx_done,
  input logic       rx_ninth,
  input logic       rx_stop
);
  p_fixed_one_r2: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[6]);

  p_ti_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[1] && !ctl_we) |=> ctl_rdata[1]);

  p_ri_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[0] && !ctl_we) |=> ctl_rdata[0]);

  p_irq_follow_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == ($past(irq_en) && ($past(ctl_rdata[1]) || $past(ctl_rdata[0])))));

  p_idle_line_r3: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  p_ren_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !ctl_rdata[4] |=> !rx_done);

  p_reject_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_done && ctl_rdata[5] && !(ctl_rdata[7] ? rx_ninth : rx_stop)
     && !ctl_rdata[0] && !ctl_we) |=> !ctl_rdata[0]);
endmodule

bind mpu_uart mpu_uart_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .ctl_we    (ctl_we),
  .ctl_rdata (ctl_rdata),
  .irq_en    (irq_en),
  .irq       (irq),
  .txd       (txd),
  .tx_busy   (tx_busy),
  .rx_done   (rx_done),
  .rx_ninth  (rx_ninth),
  .rx_stop   (rx_stop)
);

// File: tb/mpu_uart_tb_top.sv
`timescale 1ns/1ps
module mpu_uart_tb_top;
  localparam int OVS  = 16;
  localparam int DW   = 8;
  localparam int TDIV = 2;
  localparam int BITC = OVS * TDIV;

  logic          clk = 1'b0;
  logic          rst, baud_tick, ctl_we, tx_we, irq_en, irq, txd, rxd;
  logic [7:0]    ctl_wdata, ctl_rdata;
  logic [DW-1:0] tx_data, rx_data;
  logic          loop_en, brx;
  int            n_run = 0;
  int            n_fail = 0;

  assign rxd = loop_en ? txd : brx;

  always #2.5 clk = ~clk;

  mpu_uart #(.OVS(OVS), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .tx_we(tx_we),
    .tx_data(tx_data), .rx_data(rx_data), .irq_en(irq_en), .irq(irq),
    .txd(txd), .rxd(rxd)
  );

  initial begin
    int tk;
    tk = 0;
    baud_tick = 1'b0;
    forever begin
      @(negedge clk);
      tk = (tk + 1) % TDIV;
      baud_tick = (tk == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] cfgv(input bit m, input bit mce, input bit ren, input bit tb8);
    return {m, 1'b0, mce, ren, tb8, 3'b000};
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wdata = v;
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] d, input bit nine, input bit b9, input bit stp);
    brx = 1'b0;
    step(BITC);
    for (int k = 0; k < 8; k++) begin
      brx = d[k];
      step(BITC);
    end
    if (nine) begin
      brx = b9;
      step(BITC);
    end
    brx = stp;
    step(BITC);
    brx = 1'b1;
    step(2 * BITC);
  endtask

  task automatic tx_frame(input logic [7:0] d, input bit nine,
                          output logic [8:0] pay, output int ti_at, output bit stop_ok);
    int n;
    n = nine ? 9 : 8;
    pay = '0;
    ti_at = -1;
    stop_ok = 1'b0;
    tx_data = d;
    tx_we = 1'b1;
    @(negedge clk);
    tx_we = 1'b0;
    for (int c = 1; c <= (n + 2) * BITC; c++) begin
      @(negedge clk);
      for (int k = 1; k <= n; k++)
        if (c == k * BITC + BITC / 2) pay[k-1] = txd;
      if (c == (n + 1) * BITC + BITC / 2) stop_ok = txd;
      if (ti_at < 0 && ctl_rdata[1]) ti_at = c;
    end
  endtask

  task automatic wait_ri();
    for (int w = 0; w < 2000 && !ctl_rdata[0]; w++) @(negedge clk);
  endtask

  task automatic run_all();
    logic [8:0] pay;
    int ti_at, expt;
    bit stop_ok, seen;
    int hit0, hit1;

    rst = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; tx_we = 1'b0; tx_data = '0;
    irq_en = 1'b0; loop_en = 1'b0; brx = 1'b1;
    step(5);
    rst = 1'b0;
    step(2);
    chk(ctl_rdata == 8'h40, "R1 ctl reset", ctl_rdata, 8'h40);
    chk(txd == 1'b1, "R1 txd reset", txd, 1);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    chk(rx_data == 8'h00, "R1 rx_data reset", rx_data, 0);

    // R2 register layout, R12 interrupt
    wr_ctl(8'hFF);
    chk(ctl_rdata == 8'hFB, "R2 write FF", ctl_rdata, 8'hFB);
    chk(irq == 1'b0, "R12 irq masked", irq, 0);
    irq_en = 1'b1;
    step(1);
    chk(irq == 1'b1, "R12 irq on", irq, 1);
    wr_ctl(8'h00);
    chk(irq == 1'b1, "R12 irq lag", irq, 1);
    chk(ctl_rdata == 8'h40, "R2 write 00", ctl_rdata, 8'h40);
    step(1);
    chk(irq == 1'b0, "R12 irq off", irq, 0);

    // R3 R4 R5 loopback sweep over both framings
    loop_en = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 64; i++) begin
        logic [7:0] d;
        bit t8;
        d  = 8'((i * 53 + m * 29 + 5) & 255);
        t8 = (i % 2) ^ ((i / 8) % 2);
        wr_ctl(cfgv(m[0], 1'b0, 1'b1, t8));
        tx_frame(d, m[0], pay, ti_at, stop_ok);
        chk(pay[7:0] == d, "R3 data bits", pay[7:0], d);
        if (m == 1) chk(pay[8] == t8, "R3 ninth bit", pay[8], t8);
        chk(stop_ok, "R3 stop bit", stop_ok, 1);
        expt = (m == 1 ? 10 : 9) * BITC;
        chk(ti_at >= expt - TDIV && ti_at <= expt + 2, "R4 TI moment", ti_at, expt);
        wait_ri();
        chk(ctl_rdata[0] == 1'b1, "R5 RI set", ctl_rdata[0], 1);
        chk(rx_data == d, "R5 rx data", rx_data, d);
        chk(ctl_rdata[2] == (m == 1 ? t8 : 1'b1), "R5 bit2", ctl_rdata[2], (m == 1 ? t8 : 1));
        step(BITC);
      end
    end

    // R13 write while busy
    wr_ctl(cfgv(1'b1, 1'b0, 1'b1, 1'b1));
    tx_data = 8'hA5; tx_we = 1'b1; step(1); tx_we = 1'b0;
    step(100);
    tx_data = 8'h3C; tx_we = 1'b1; step(1); tx_we = 1'b0;
    wait_ri();
    chk(rx_data == 8'hA5, "R13 first frame kept", rx_data, 8'hA5);
    step(BITC);
    wr_ctl(cfgv(1'b1, 1'b0, 1'b1, 1'b1));
    begin
      int lows;
      lows = 0;
      for (int c = 0; c < 600; c++) begin
        @(negedge clk);
        if (!txd) lows++;
      end
      chk(lows == 0, "R13 no second frame", lows, 0);
      chk(ctl_rdata[0] == 1'b0, "R13 no second RI", ctl_rdata[0], 0);
    end

    // R6 receive disabled
    loop_en = 1'b0;
    wr_ctl(cfgv(1'b0, 1'b0, 1'b0, 1'b0));
    rx_send(8'h5A, 1'b0, 1'b0, 1'b1);
    chk(ctl_rdata[0] == 1'b0, "R6 RI stays clear", ctl_rdata[0], 0);
    chk(rx_data == 8'hA5, "R6 rx_data kept", rx_data, 8'hA5);

    // R7 eight-bit qualifier on stop bit
    wr_ctl(cfgv(1'b0, 1'b1, 1'b1, 1'b0));
    rx_send(8'hC3, 1'b0, 1'b0, 1'b0);
    chk(ctl_rdata[0] == 1'b0, "R7 bad stop rejected", ctl_rdata[0], 0);
    chk(rx_data == 8'hA5, "R9 data kept", rx_data, 8'hA5);
    chk(ctl_rdata[2] == 1'b1, "R9 bit2 kept", ctl_rdata[2], 1);
    wr_ctl(cfgv(1'b0, 1'b0, 1'b1, 1'b0));
    rx_send(8'h96, 1'b0, 1'b0, 1'b0);
    chk(ctl_rdata[0] == 1'b1, "R7 bad stop accepted unqualified", ctl_rdata[0], 1);
    chk(rx_data == 8'h96, "R7 data", rx_data, 8'h96);
    chk(ctl_rdata[2] == 1'b0, "R7 bit2 stop", ctl_rdata[2], 0);
    wr_ctl(cfgv(1'b0, 1'b1, 1'b1, 1'b0));
    rx_send(8'h69, 1'b0, 1'b0, 1'b1);
    chk(ctl_rdata[0] == 1'b1, "R7 good stop accepted", ctl_rdata[0], 1);
    chk(rx_data == 8'h69, "R7 data qualified", rx_data, 8'h69);
    chk(ctl_rdata[2] == 1'b1, "R7 bit2 high", ctl_rdata[2], 1);

    // R8 nine-bit qualifier on ninth bit
    wr_ctl(cfgv(1'b1, 1'b1, 1'b1, 1'b0));
    rx_send(8'h0F, 1'b1, 1'b0, 1'b1);
    chk(ctl_rdata[0] == 1'b0, "R8 ninth low rejected", ctl_rdata[0], 0);
    chk(rx_data == 8'h69, "R9 data kept 9bit", rx_data, 8'h69);
    chk(ctl_rdata[2] == 1'b1, "R9 bit2 kept 9bit", ctl_rdata[2], 1);
    rx_send(8'hF0, 1'b1, 1'b1, 1'b1);
    chk(ctl_rdata[0] == 1'b1, "R8 ninth high accepted", ctl_rdata[0], 1);
    chk(rx_data == 8'hF0, "R8 data", rx_data, 8'hF0);
    wr_ctl(cfgv(1'b1, 1'b0, 1'b1, 1'b0));
    rx_send(8'h81, 1'b1, 1'b0, 1'b1);
    chk(ctl_rdata[0] == 1'b1, "R8 unqualified accepted", ctl_rdata[0], 1);
    chk(ctl_rdata[2] == 1'b0, "R8 bit2 ninth", ctl_rdata[2], 0);

    // R10 start glitch
    wr_ctl(cfgv(1'b0, 1'b0, 1'b1, 1'b0));
    brx = 1'b0;
    step(3 * TDIV);
    brx = 1'b1;
    step(2 * BITC);
    chk(ctl_rdata[0] == 1'b0, "R10 glitch no RI", ctl_rdata[0], 0);
    chk(rx_data == 8'h81, "R10 glitch no data", rx_data, 8'h81);
    rx_send(8'h24, 1'b0, 1'b0, 1'b1);
    chk(rx_data == 8'h24, "R10 recovers", rx_data, 8'h24);

    // R11 sticky then set-versus-clear collision sweep
    step(500);
    chk(ctl_rdata[0] == 1'b1, "R11 RI sticky", ctl_rdata[0], 1);
    hit0 = 0;
    hit1 = 0;
    for (int w = 296; w <= 320; w++) begin
      wr_ctl(cfgv(1'b0, 1'b0, 1'b1, 1'b0));
      fork
        rx_send(8'h5C, 1'b0, 1'b0, 1'b1);
        begin
          step(w);
          seen = ctl_rdata[0];
          ctl_wdata = cfgv(1'b0, 1'b0, 1'b1, 1'b0);
          ctl_we = 1'b1;
          @(negedge clk);
          ctl_we = 1'b0;
        end
      join
      if (seen) hit1++; else hit0++;
      chk(ctl_rdata[0] == !seen, "R11 collision", ctl_rdata[0], !seen);
    end
    chk(hit0 > 0 && hit1 > 0, "R11 window spans set", hit0 * 100 + hit1, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule